// File: doc/BRIEF.md
# Dual-Channel Drive I/O Decoder

This block sits behind the host's programmed-I/O path of a two-channel disk controller. It takes each host access and compares the address with five windows. These are the primary command block, the primary control block, the secondary command block, the secondary control block and the bus-master register file. From the match it works out which window was hit, the offset inside that window, which channel the access belongs to and which of the four attached drives it targets. The window base addresses arrive as inputs from the configuration logic. The window sizes are parameters.

Each channel keeps a one-bit record of which of its two drives was last selected. The block updates that record by watching writes to the drive-select register of the command block. Drive-register accesses leave on a drive request port, tagged with a two-bit drive index, a byte-access flag and a command-versus-control flag. Bus-master accesses leave on a separate port, tagged with the channel they belong to. Misses and illegal sizes produce a one-cycle error pulse instead of a request. All outputs are registered, so a request shows up one clock after it is presented.

Top module: `pio_chan_decoder`

## Requirements
- R1: A window matches when base <= address < base + size. The forwarded offset is address minus base. The first address past a window's end does not match that window.
- R2: When windows overlap, the lowest-numbered window wins, in this order: 0 primary command, 1 primary control, 2 secondary command, 3 secondary control, 4 bus master.
- R3: A bus-master access is tagged secondary (bmSecondary = 1) when its local offset is BM_SIZE/2 or above, and primary otherwise.
- R4: A forwarded write to offset SEL_OFFSET (6) of a command window loads that channel's selected-drive bit from write-data bit DEV_BIT (4). Reads, other offsets and control-window writes leave the bit unchanged.
- R5: drvIndex equals 2 × channel + selected-drive bit, where primary is 0 and secondary is 1. A write to the select register is itself routed using the newly written bit.
- R6: While ioEnable is low, a request produces no drive request, no bus-master request and no error, and it leaves the selected-drive bits unchanged.
- R7: reqSize is a byte count. The values 1, 2 and 4 are legal, except that 4 is illegal for command and control windows. An illegal size raises decodeError, forwards nothing and leaves the selected-drive bits unchanged.
- R8: An enabled request that matches no window raises decodeError for one cycle and has no other effect.
- R9: drvByte is 1 exactly when reqSize is 1. drvCmdBlk is 1 for command windows and 0 for control windows.
- R10: Reset clears both selected-drive bits and drops drvValid, bmValid and decodeError.
- R11: Every enabled request produces exactly one of drvValid, bmValid or decodeError, one clock later and for one cycle. No request produces none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioEnable | input | 1 | I/O space enable; when low, all requests are dropped |
| priCmdBase | input | AW | Base address of the primary command window |
| priCtlBase | input | AW | Base address of the primary control window |
| secCmdBase | input | AW | Base address of the secondary command window |
| secCtlBase | input | AW | Base address of the secondary control window |
| bmBase | input | AW | Base address of the bus-master window |
| reqValid | input | 1 | Host access strobe, one cycle per access |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | AW | Access address |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data |
| drvValid | output | 1 | Drive request strobe |
| drvWrite | output | 1 | Drive request is a write |
| drvIndex | output | 2 | Target drive, 0 to 3 |
| drvOffset | output | OFFW | Register offset inside the window |
| drvByte | output | 1 | Single-byte access |
| drvCmdBlk | output | 1 | 1 for command block, 0 for control block |
| drvWdata | output | 32 | Write data for the drive |
| bmValid | output | 1 | Bus-master register request strobe |
| bmWrite | output | 1 | Bus-master request is a write |
| bmSecondary | output | 1 | Register belongs to the secondary channel |
| bmOffset | output | OFFW | Offset inside the bus-master window |
| bmSize | output | 3 | Access size in bytes |
| bmWdata | output | 32 | Write data for the bus-master registers |
| decodeError | output | 1 | One-cycle pulse for a miss or an illegal size |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-byte command window, a 4-byte control window and a 16-byte bus-master window. With the 16-byte bus-master window the channel split falls at offset 8, and both edges of that split (offsets 7/8 and 15/16) can be reached with single accesses. The 4-byte control window puts the select offset 6 outside any control window, so select snooping can only come from command windows. By reprogramming the base inputs during the run, the bench makes windows overlap. This tests the priority order on live traffic without any change to the parameters.

// File: rtl/pio_dec_pkg.sv
package pio_dec_pkg;

  localparam int NUM_WIN = 5;
  localparam int WIN_BM  = 4;

  typedef struct packed {
    logic       drvFire;
    logic       bmFire;
    logic       errFire;
    logic       cmdBlk;
    logic       winSec;
    logic [2:0] winSel;
  } pioStrobes_t;

endpackage

// File: rtl/pio_window_match.sv
module pio_window_match #(
  parameter int AW   = 16,
  parameter int SIZE = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          hit,
  output logic [AW-1:0] offset
);
  localparam logic [AW-1:0] SIZE_V = AW'(SIZE);

  always_comb begin
    offset = addr - base;
    hit    = (addr >= base) && (offset < SIZE_V);
  end
endmodule

// File: rtl/pio_dec_ctrl.sv
module pio_dec_ctrl
  import pio_dec_pkg::*;
(
  input  logic               reqValid,
  input  logic               ioEnable,
  input  logic [2:0]         reqSize,
  input  logic [NUM_WIN-1:0] winHit,
  output pioStrobes_t        strb
);
  logic       anyHit;
  logic [2:0] sel;
  logic       sizeOk;
  logic       active;

  always_comb begin
    sel = 3'd0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winHit[i]) sel = 3'(i);
    end
  end

  always_comb begin
    anyHit = |winHit;
    active = reqValid && ioEnable;
    unique case (reqSize)
      3'd1, 3'd2: sizeOk = 1'b1;
      3'd4:       sizeOk = (sel == 3'(WIN_BM));
      default:    sizeOk = 1'b0;
    endcase
    strb.winSel  = sel;
    strb.cmdBlk  = (sel == 3'd0) || (sel == 3'd2);
    strb.winSec  = (sel == 3'd2) || (sel == 3'd3);
    strb.errFire = active && (!anyHit || !sizeOk);
    strb.drvFire = active && anyHit && sizeOk && (sel != 3'(WIN_BM));
    strb.bmFire  = active && anyHit && sizeOk && (sel == 3'(WIN_BM));
  end
endmodule

// File: rtl/pio_dec_datapath.sv
module pio_dec_datapath
  import pio_dec_pkg::*;
#(
  parameter int AW         = 16,
  parameter int OFFW       = 4,
  parameter int BM_SIZE    = 16,
  parameter int SEL_OFFSET = 6,
  parameter int DEV_BIT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobes_t       strb,
  input  logic [AW-1:0]     winOff [NUM_WIN],
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              drvValid,
  output logic              drvWrite,
  output logic [1:0]        drvIndex,
  output logic [OFFW-1:0]   drvOffset,
  output logic              drvByte,
  output logic              drvCmdBlk,
  output logic [31:0]       drvWdata,
  output logic              bmValid,
  output logic              bmWrite,
  output logic              bmSecondary,
  output logic [OFFW-1:0]   bmOffset,
  output logic [2:0]        bmSize,
  output logic [31:0]       bmWdata,
  output logic              decodeError
);
  localparam logic [OFFW-1:0] HALF_BM = OFFW'(BM_SIZE / 2);
  localparam logic [OFFW-1:0] SEL_OFF = OFFW'(SEL_OFFSET);

  logic [1:0]      shadowDev;
  logic [OFFW-1:0] localOff;
  logic            chan;
  logic            selWrite;
  logic            devNow;

  always_comb begin
    localOff = OFFW'(winOff[strb.winSel]);
    chan     = strb.bmFire ? (localOff >= HALF_BM) : strb.winSec;
    selWrite = strb.drvFire && reqWrite && strb.cmdBlk && (localOff == SEL_OFF);
    devNow   = selWrite ? reqWdata[DEV_BIT] : shadowDev[chan];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowDev <= 2'b00;
    else if (selWrite) shadowDev[chan] <= reqWdata[DEV_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvValid    <= 1'b0;
      bmValid     <= 1'b0;
      decodeError <= 1'b0;
    end else begin
      drvValid    <= strb.drvFire;
      bmValid     <= strb.bmFire;
      decodeError <= strb.errFire;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvWrite  <= 1'b0;
      drvIndex  <= 2'd0;
      drvOffset <= '0;
      drvByte   <= 1'b0;
      drvCmdBlk <= 1'b0;
      drvWdata  <= '0;
    end else if (strb.drvFire) begin
      drvWrite  <= reqWrite;
      drvIndex  <= {chan, devNow};
      drvOffset <= localOff;
      drvByte   <= (reqSize == 3'd1);
      drvCmdBlk <= strb.cmdBlk;
      drvWdata  <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bmWrite     <= 1'b0;
      bmSecondary <= 1'b0;
      bmOffset    <= '0;
      bmSize      <= 3'd0;
      bmWdata     <= '0;
    end else if (strb.bmFire) begin
      bmWrite     <= reqWrite;
      bmSecondary <= chan;
      bmOffset    <= localOff;
      bmSize      <= reqSize;
      bmWdata     <= reqWdata;
    end
  end
endmodule

// File: rtl/pio_chan_decoder.sv
module pio_chan_decoder
  import pio_dec_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CMD_SIZE   = 8,
  parameter int CTL_SIZE   = 4,
  parameter int BM_SIZE    = 16,
  parameter int SEL_OFFSET = 6,
  parameter int DEV_BIT    = 4,
  parameter int OFFW       = $clog2(BM_SIZE > CMD_SIZE ? BM_SIZE : CMD_SIZE)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ioEnable,
  input  logic [AW-1:0]   priCmdBase,
  input  logic [AW-1:0]   priCtlBase,
  input  logic [AW-1:0]   secCmdBase,
  input  logic [AW-1:0]   secCtlBase,
  input  logic [AW-1:0]   bmBase,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [AW-1:0]   reqAddr,
  input  logic [2:0]      reqSize,
  input  logic [31:0]     reqWdata,
  output logic            drvValid,
  output logic            drvWrite,
  output logic [1:0]      drvIndex,
  output logic [OFFW-1:0] drvOffset,
  output logic            drvByte,
  output logic            drvCmdBlk,
  output logic [31:0]     drvWdata,
  output logic            bmValid,
  output logic            bmWrite,
  output logic            bmSecondary,
  output logic [OFFW-1:0] bmOffset,
  output logic [2:0]      bmSize,
  output logic [31:0]     bmWdata,
  output logic            decodeError
);
  logic [AW-1:0]      baseArr [NUM_WIN];
  logic [AW-1:0]      winOff  [NUM_WIN];
  logic [NUM_WIN-1:0] winHit;
  pioStrobes_t        strb;

  assign baseArr[0] = priCmdBase;
  assign baseArr[1] = priCtlBase;
  assign baseArr[2] = secCmdBase;
  assign baseArr[3] = secCtlBase;
  assign baseArr[4] = bmBase;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int WSZ = (w == WIN_BM) ? BM_SIZE :
                         ((w % 2) == 1) ? CTL_SIZE : CMD_SIZE;
    pio_window_match #(.AW(AW), .SIZE(WSZ)) u_match (
      .addr   (reqAddr),
      .base   (baseArr[w]),
      .hit    (winHit[w]),
      .offset (winOff[w])
    );
  end

  pio_dec_ctrl u_ctrl (
    .reqValid (reqValid),
    .ioEnable (ioEnable),
    .reqSize  (reqSize),
    .winHit   (winHit),
    .strb     (strb)
  );

  pio_dec_datapath #(
    .AW(AW), .OFFW(OFFW), .BM_SIZE(BM_SIZE),
    .SEL_OFFSET(SEL_OFFSET), .DEV_BIT(DEV_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .winOff      (winOff),
    .reqWrite    (reqWrite),
    .reqSize     (reqSize),
    .reqWdata    (reqWdata),
    .drvValid    (drvValid),
    .drvWrite    (drvWrite),
    .drvIndex    (drvIndex),
    .drvOffset   (drvOffset),
    .drvByte     (drvByte),
    .drvCmdBlk   (drvCmdBlk),
    .drvWdata    (drvWdata),
    .bmValid     (bmValid),
    .bmWrite     (bmWrite),
    .bmSecondary (bmSecondary),
    .bmOffset    (bmOffset),
    .bmSize      (bmSize),
    .bmWdata     (bmWdata),
    .decodeError (decodeError)
  );
endmodule

// File: rtl/pio_chan_decoder_chk.sv
module pio_chan_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ioEnable,
  input logic       reqValid,
  input logic [2:0] reqSize,
  input logic       drvValid,
  input logic       bmValid,
  input logic       decodeError
);
  // R11
  one_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drvValid, bmValid, decodeError}));

  // R11
  answer_every_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ioEnable) |=> (drvValid || bmValid || decodeError));

  // R11
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(drvValid || bmValid || decodeError));

  // R6
  disabled_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !ioEnable) |=> !(drvValid || bmValid || decodeError));

  // R7
  odd_size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ioEnable && (reqSize == 3'd3 || reqSize == 3'd0)) |=> decodeError);
endmodule

bind pio_chan_decoder pio_chan_decoder_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ioEnable    (ioEnable),
  .reqValid    (reqValid),
  .reqSize     (reqSize),
  .drvValid    (drvValid),
  .bmValid     (bmValid),
  .decodeError (decodeError)
);

// File: tb/pio_chan_decoder_test.sv
module pio_chan_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioEnable = 1'b0;
  logic [15:0] priCmdBase = 16'h01F0, priCtlBase = 16'h03F4;
  logic [15:0] secCmdBase = 16'h0170, secCtlBase = 16'h0374;
  logic [15:0] bmBase = 16'hC000;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [2:0]  reqSize = 3'd1;
  logic [31:0] reqWdata = '0;
  logic        drvValid, drvWrite, drvByte, drvCmdBlk;
  logic [1:0]  drvIndex;
  logic [3:0]  drvOffset, bmOffset;
  logic [31:0] drvWdata, bmWdata;
  logic        bmValid, bmWrite, bmSecondary, decodeError;
  logic [2:0]  bmSize;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pio_chan_decoder uut (
    .clk(clk), .rstN(rstN), .ioEnable(ioEnable),
    .priCmdBase(priCmdBase), .priCtlBase(priCtlBase),
    .secCmdBase(secCmdBase), .secCtlBase(secCtlBase), .bmBase(bmBase),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata),
    .drvValid(drvValid), .drvWrite(drvWrite), .drvIndex(drvIndex),
    .drvOffset(drvOffset), .drvByte(drvByte), .drvCmdBlk(drvCmdBlk),
    .drvWdata(drvWdata), .bmValid(bmValid), .bmWrite(bmWrite),
    .bmSecondary(bmSecondary), .bmOffset(bmOffset), .bmSize(bmSize),
    .bmWdata(bmWdata), .decodeError(decodeError)
  );

  // kind: 0 none, 1 drive, 2 bus master, 3 error
  // row: wr, addr, size, data, kind, idx, off, byte, cmd, sec
  localparam int NV = 22;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 16'h01F0, 3'd1, 8'h00, 2'd1, 2'd0, 4'd0,  1'b1, 1'b1, 1'b0}, // R1 R9
    {1'b0, 16'h01F7, 3'd2, 8'h00, 2'd1, 2'd0, 4'd7,  1'b0, 1'b1, 1'b0}, // R1 last byte
    {1'b0, 16'h01F8, 3'd1, 8'h00, 2'd3, 2'd0, 4'd0,  1'b0, 1'b0, 1'b0}, // R1 R8 one past end
    {1'b1, 16'h01F6, 3'd1, 8'h10, 2'd1, 2'd1, 4'd6,  1'b1, 1'b1, 1'b0}, // R4 R5 select drive 1
    {1'b0, 16'h01F6, 3'd1, 8'h00, 2'd1, 2'd1, 4'd6,  1'b1, 1'b1, 1'b0}, // R4 read no snoop
    {1'b0, 16'h03F6, 3'd1, 8'h00, 2'd1, 2'd1, 4'd2,  1'b1, 1'b0, 1'b0}, // R9 control window
    {1'b0, 16'h0172, 3'd2, 8'h00, 2'd1, 2'd2, 4'd2,  1'b0, 1'b1, 1'b0}, // R5 secondary
    {1'b1, 16'h0176, 3'd1, 8'h10, 2'd1, 2'd3, 4'd6,  1'b1, 1'b1, 1'b0}, // R5 sec drive 1
    {1'b1, 16'h0376, 3'd1, 8'h00, 2'd1, 2'd3, 4'd2,  1'b1, 1'b0, 1'b0}, // R4 ctl write no snoop
    {1'b1, 16'h01F6, 3'd1, 8'hEF, 2'd1, 2'd0, 4'd6,  1'b1, 1'b1, 1'b0}, // R4 bit4 clear
    {1'b0, 16'h01F2, 3'd1, 8'h00, 2'd1, 2'd0, 4'd2,  1'b1, 1'b1, 1'b0}, // R5
    {1'b1, 16'h01F5, 3'd1, 8'h10, 2'd1, 2'd0, 4'd5,  1'b1, 1'b1, 1'b0}, // R4 other offset
    {1'b0, 16'h01F0, 3'd1, 8'h00, 2'd1, 2'd0, 4'd0,  1'b1, 1'b1, 1'b0}, // R4 still drive 0
    {1'b0, 16'hC002, 3'd1, 8'h00, 2'd2, 2'd0, 4'd2,  1'b0, 1'b0, 1'b0}, // R3 primary
    {1'b0, 16'hC007, 3'd1, 8'h00, 2'd2, 2'd0, 4'd7,  1'b0, 1'b0, 1'b0}, // R3 below half
    {1'b0, 16'hC008, 3'd4, 8'h00, 2'd2, 2'd0, 4'd8,  1'b0, 1'b0, 1'b1}, // R3 R7 dword
    {1'b0, 16'hC00F, 3'd1, 8'h00, 2'd2, 2'd0, 4'd15, 1'b0, 1'b0, 1'b1}, // R3
    {1'b0, 16'hC010, 3'd1, 8'h00, 2'd3, 2'd0, 4'd0,  1'b0, 1'b0, 1'b0}, // R8
    {1'b0, 16'h01F0, 3'd4, 8'h00, 2'd3, 2'd0, 4'd0,  1'b0, 1'b0, 1'b0}, // R7 dword cmd
    {1'b0, 16'h01F0, 3'd3, 8'h00, 2'd3, 2'd0, 4'd0,  1'b0, 1'b0, 1'b0}, // R7 size 3
    {1'b1, 16'h0176, 3'd4, 8'h00, 2'd3, 2'd0, 4'd0,  1'b0, 1'b0, 1'b0}, // R7 no snoop
    {1'b0, 16'h0177, 3'd2, 8'h00, 2'd1, 2'd3, 4'd7,  1'b0, 1'b1, 1'b0}  // R7 sec still 1
  };

  function automatic logic [10:0] observed();
    if (drvValid && !bmValid && !decodeError)
      return {2'd1, drvIndex, drvOffset, drvByte, drvCmdBlk, 1'b0};
    if (bmValid && !drvValid && !decodeError)
      return {2'd2, 2'd0, bmOffset, 1'b0, 1'b0, bmSecondary};
    if (decodeError && !drvValid && !bmValid)
      return 11'b11_00_0000_000;
    if (!drvValid && !bmValid && !decodeError)
      return 11'd0;
    return 11'h7FF;
  endfunction

  task automatic check(input string req, input logic [10:0] exp);
    logic [10:0] act = observed();
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [2:0] sz,
                        input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz;
    reqWdata = {24'h00A5C3, d};
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", 11'd0);
    rstN = 1'b1;
    ioEnable = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][38], VEC[i][37:22], VEC[i][21:19], VEC[i][18:11]);
      check($sformatf("R1-table row %0d", i), VEC[i][10:0]);
    end

    // R11 single-cycle pulse, and wdata/write pass through
    access(1'b1, 16'h01F3, 3'd2, 8'h5A);
    compared++;
    if (!(drvWrite && drvWdata == 32'h00A5C35A)) begin
      mismatched++;
      $display("FAIL R11 write data: got %h expected 00a5c35a", drvWdata);
    end
    @(negedge clk);
    check("R11 pulse ends", 11'd0);

    // R6 disabled: select write dropped, no outputs
    ioEnable = 1'b0;
    access(1'b1, 16'h01F6, 3'd1, 8'h10);
    check("R6 no output", 11'd0);
    access(1'b0, 16'hC000, 3'd1, 8'h00);
    check("R6 bm dropped", 11'd0);
    ioEnable = 1'b1;
    access(1'b0, 16'h01F1, 3'd1, 8'h00);
    check("R6 shadow kept", {2'd1, 2'd0, 4'd1, 1'b1, 1'b1, 1'b0});

    // R2 priority on overlap
    priCtlBase = 16'h01F0;
    access(1'b0, 16'h01F2, 3'd1, 8'h00);
    check("R2 cmd over ctl", {2'd1, 2'd0, 4'd2, 1'b1, 1'b1, 1'b0});
    bmBase = 16'h0170;
    access(1'b0, 16'h0171, 3'd2, 8'h00);
    check("R2 sec cmd over bm", {2'd1, 2'd3, 4'd1, 1'b0, 1'b1, 1'b0});
    access(1'b0, 16'h0179, 3'd1, 8'h00);
    check("R2 bm beyond cmd", {2'd2, 2'd0, 4'd9, 1'b0, 1'b0, 1'b1});
    priCtlBase = 16'h03F4;
    bmBase = 16'hC000;

    // R10 reset clears shadow bits
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R10 outputs in reset", 11'd0);
    rstN = 1'b1;
    access(1'b0, 16'h0170, 3'd1, 8'h00);
    check("R10 sec shadow cleared", {2'd1, 2'd2, 4'd0, 1'b1, 1'b1, 1'b0});

    done = 1;
    finishRun();
  end
endmodule